// File: doc/BRIEF.md
# Duplicated-execution add-multiply unit with compare and rewind

The block computes a short dependent chain of two operations on a fixed cycle schedule and protects it with duplicated execution. The first operation adds two W-bit operands. The second operation multiplies that sum by the second operand and gives a 2W-bit product. Each operation runs twice, once as a primary copy and once as a secondary copy, and each copy goes into its own register. Once both copies of an operation have been written, the block compares them. When the copies differ, the block cannot tell which one is wrong. It rewinds its step counter to the step where that operation's primary copy was issued and runs again from there. This re-runs the failing operation and every dependent operation that may have consumed the suspect value. After the rewound span, the normal schedule continues.

The schedule is a small table indexed by a step counter. Each row names the copy issued in that step, the compare made in that step, and the step to rewind to if the compare fails. A state machine steps through the table in four states:
- `ST_IDLE` waits for a start request.
- `ST_RUN` executes the schedule.
- `ST_REWIND` re-executes a rewound span.
- `ST_DONE` presents completion for one cycle.

The transitions are:
- start (`ST_IDLE`→`ST_RUN`)
- mismatch (`ST_RUN`→`ST_REWIND`, and `ST_REWIND`→`ST_REWIND`)
- span end (`ST_REWIND`→`ST_RUN`)
- final pass (`ST_RUN`→`ST_DONE` or `ST_REWIND`→`ST_DONE`)
- retire (`ST_DONE`→`ST_IDLE`)

Fault-injection strobes flip one bit of a chosen copy, so that detection and correction can be exercised.

Top module: `dmr_replay_ctrl`

## Requirements
- R1: During and after reset, `done`, `replay` and `penalty_over` are 0, and `replay_cycles` and `result` are 0. A `start` seen in `ST_IDLE` captures both operands and begins step 0 in the next cycle.
- R2: Without faults, `result` equals ((opnd_a + opnd_b) mod 2^W) × opnd_b as a 2W-bit value. `done` is high for exactly one cycle.
- R3: Schedule, counting steps from the cycle after the start edge:
  - Step 0 writes the add primary copy. Step 1 writes the add secondary copy. Step 2 compares the add copies.
  - Step 2 issues the multiply primary from the add primary copy. Step 3 issues the multiply secondary from the add secondary copy.
  - The multiply has a latency of 2 steps, so its compare is at step 5.
  - Without faults, `done` rises at the 6th rising edge after the start edge.
- R4: An add-copy mismatch at step 2 rewinds to step 0. This costs 3 replayed cycles, delays `done` by 3 cycles, and still gives the correct result.
- R5: A multiply-copy mismatch at step 5 rewinds to step 2. This costs 4 replayed cycles, delays `done` by 4 cycles, and still gives the correct result.
- R6: `replay` is high exactly in the cycles of a rewound span. `replay_cycles` counts those cycles and is cleared by the next start.
- R7: `penalty_over` is set when a rewound span (detect step − rewind step + 1) exceeds PENALTY_MAX, and it holds until the next start. With PENALTY_MAX = 4, neither span sets it. With PENALTY_MAX = 3, only the multiply span (4) sets it.
- R8: Copy index k is 0 for the add primary, 1 for the add secondary, 2 for the multiply primary and 3 for the multiply secondary.
  - `inj_exec[k]` flips bit FLIP_BIT (default 0) of the value written into copy k in a cycle that writes it.
  - `inj_reg[k]` flips that bit of the stored copy k in a cycle that does not write it.
- R9: An upset of a copy after its last use and compare has no effect. An upset of the add primary at step 3 and an upset of the multiply secondary at step 5 both leave the result correct, cause no replay, and do not delay `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation when idle |
| opnd_a | input | W | First addend |
| opnd_b | input | W | Second addend and multiplier |
| inj_exec | input | 4 | Execution fault strobes, one per copy |
| inj_reg | input | 4 | Register upset strobes, one per copy |
| result | output | 2W | Multiply primary copy, the final result |
| done | output | 1 | One-cycle completion pulse |
| replay | output | 1 | High while a rewound span runs |
| replay_cycles | output | CNT_W | Replayed cycles in the current run |
| penalty_over | output | 1 | A span exceeded PENALTY_MAX |

## Verification
Every computation is due a fixed number of rising edges after the start edge. That number is 6 with no fault, 9 after an add mismatch and 10 after a multiply mismatch. The replayed-cycle count is 0, 3 or 4 to match. The driver pushes the expected product, latency and span into a queue when it issues a start. It places each fault strobe in the exact step that writes or holds the target copy. The monitor counts cycles from the start edge at falling edges, tallies the cycles with `replay` high, and on `done` pops the queue and compares every field. A second instance with a tighter penalty bound runs on the same stimulus, so that the penalty flag is seen both set and clear.

// File: rtl/dmr_sched_pkg.sv
package dmr_sched_pkg;
    localparam int STEP_W  = 3;
    localparam int MUL_LAT = 2;
    localparam int A_PRI   = 0;
    localparam int A_SEC   = 1;
    localparam int B_PRI   = 2;
    localparam int B_SEC   = 3;
    localparam int A_CMP   = A_SEC + 1;
    localparam int B_CMP   = B_SEC + MUL_LAT;
    localparam int LAST    = B_CMP;

    typedef enum logic [2:0] {ISS_NONE, ISS_AP, ISS_AS, ISS_BP, ISS_BS} issue_e;
    typedef enum logic [1:0] {CMP_NONE, CMP_A, CMP_B} cmp_e;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_REWIND, ST_DONE} state_e;

    typedef struct packed {
        issue_e              issue;
        cmp_e                cmp;
        logic [STEP_W-1:0]   rewind;
    } row_t;

    function automatic row_t sched_row(input logic [STEP_W-1:0] s);
        row_t r;
        r.issue  = ISS_NONE;
        r.cmp    = CMP_NONE;
        r.rewind = '0;
        if (s == STEP_W'(A_PRI))      r.issue = ISS_AP;
        else if (s == STEP_W'(A_SEC)) r.issue = ISS_AS;
        else if (s == STEP_W'(B_PRI)) r.issue = ISS_BP;
        else if (s == STEP_W'(B_SEC)) r.issue = ISS_BS;
        if (s == STEP_W'(A_CMP)) begin
            r.cmp    = CMP_A;
            r.rewind = STEP_W'(A_PRI);
        end else if (s == STEP_W'(B_CMP)) begin
            r.cmp    = CMP_B;
            r.rewind = STEP_W'(B_PRI);
        end
        return r;
    endfunction
endpackage

// File: rtl/dmr_sched_rom.sv
module dmr_sched_rom
    import dmr_sched_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    output row_t              row
);
    always_comb row = sched_row(step);
endmodule

// File: rtl/dmr_copy_reg.sv
module dmr_copy_reg #(
    parameter int W        = 16,
    parameter int FLIP_BIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    input  logic         inj_exec,
    input  logic         inj_reg,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MASK = W'(1) << FLIP_BIT;

    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (we)      q <= inj_exec ? (d ^ MASK) : d;
        else if (inj_reg) q <= q ^ MASK;
    end
endmodule

// File: rtl/dmr_mul_pipe.sv
module dmr_mul_pipe #(
    parameter int W   = 16,
    parameter int LAT = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush,
    input  logic           in_vld,
    input  logic           in_sec,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic           out_vld,
    output logic           out_sec,
    output logic [2*W-1:0] out_prod
);
    localparam int DEPTH = LAT - 1;
    localparam int PW    = 2 * W;

    logic          vld_q  [DEPTH];
    logic          sec_q  [DEPTH];
    logic [PW-1:0] prod_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld_q[0]  <= 1'b0;
            sec_q[0]  <= 1'b0;
            prod_q[0] <= '0;
        end else begin
            vld_q[0]  <= in_vld;
            sec_q[0]  <= in_sec;
            prod_q[0] <= PW'(x) * PW'(y);
        end
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                vld_q[g]  <= 1'b0;
                sec_q[g]  <= 1'b0;
                prod_q[g] <= '0;
            end else begin
                vld_q[g]  <= vld_q[g-1];
                sec_q[g]  <= sec_q[g-1];
                prod_q[g] <= prod_q[g-1];
            end
        end
    end

    assign out_vld  = vld_q[DEPTH-1];
    assign out_sec  = sec_q[DEPTH-1];
    assign out_prod = prod_q[DEPTH-1];
endmodule

// File: rtl/dmr_replay_ctrl.sv
module dmr_replay_ctrl
    import dmr_sched_pkg::*;
#(
    parameter int W           = 16,
    parameter int PENALTY_MAX = 4,
    parameter int FLIP_BIT    = 0,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [3:0]       inj_exec,
    input  logic [3:0]       inj_reg,
    output logic [2*W-1:0]   result,
    output logic             done,
    output logic             replay,
    output logic [CNT_W-1:0] replay_cycles,
    output logic             penalty_over
);
    localparam int PW   = 2 * W;
    localparam int SP_W = STEP_W + 1;

    state_e            state_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] end_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              pen_q;
    logic [W-1:0]      opa_q;
    logic [W-1:0]      opb_q;

    row_t              row;
    logic              active;
    logic [W-1:0]      sum;
    logic [1:0]        a_we;
    logic [W-1:0]      a_q [2];
    logic [PW-1:0]     b_q [2];
    logic              mul_in_vld;
    logic              mul_in_sec;
    logic [W-1:0]      mul_x;
    logic              mul_out_vld;
    logic              mul_out_sec;
    logic [PW-1:0]     mul_out_prod;
    logic              mis_a;
    logic              mis_b;
    logic              mis;
    logic              last_ok;
    logic [SP_W-1:0]   span;

    dmr_sched_rom u_rom (.step(step_q), .row(row));

    assign active = (state_q == ST_RUN) || (state_q == ST_REWIND);
    assign sum    = opa_q + opb_q;
    assign a_we[0] = active && (row.issue == ISS_AP);
    assign a_we[1] = active && (row.issue == ISS_AS);

    for (genvar g = 0; g < 2; g++) begin : g_add_copy
        dmr_copy_reg #(.W(W), .FLIP_BIT(FLIP_BIT)) u_copy (
            .clk(clk), .rst_n(rst_n), .we(a_we[g]), .d(sum),
            .inj_exec(inj_exec[g]), .inj_reg(inj_reg[g]), .q(a_q[g])
        );
    end

    // Primary multiply reads the add primary copy; secondary reads the add secondary copy.
    assign mul_in_vld = active && ((row.issue == ISS_BP) || (row.issue == ISS_BS));
    assign mul_in_sec = (row.issue == ISS_BS);
    assign mul_x      = mul_in_sec ? a_q[1] : a_q[0];

    dmr_mul_pipe #(.W(W), .LAT(MUL_LAT)) u_mul (
        .clk(clk), .rst_n(rst_n), .flush(mis),
        .in_vld(mul_in_vld), .in_sec(mul_in_sec), .x(mul_x), .y(opb_q),
        .out_vld(mul_out_vld), .out_sec(mul_out_sec), .out_prod(mul_out_prod)
    );

    for (genvar g = 0; g < 2; g++) begin : g_mul_copy
        dmr_copy_reg #(.W(PW), .FLIP_BIT(FLIP_BIT)) u_copy (
            .clk(clk), .rst_n(rst_n),
            .we(mul_out_vld && (mul_out_sec == 1'(g))), .d(mul_out_prod),
            .inj_exec(inj_exec[2+g]), .inj_reg(inj_reg[2+g]), .q(b_q[g])
        );
    end

    assign mis_a   = active && (row.cmp == CMP_A) && (a_q[0] != a_q[1]);
    assign mis_b   = active && (row.cmp == CMP_B) && (b_q[0] != b_q[1]);
    assign mis     = mis_a || mis_b;
    assign last_ok = active && (step_q == STEP_W'(LAST)) && !mis;
    assign span    = SP_W'(step_q) - SP_W'(row.rewind) + SP_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
        end else if ((state_q == ST_IDLE) && start) begin
            opa_q <= opnd_a;
            opb_q <= opnd_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            end_q   <= '0;
            cnt_q   <= '0;
            pen_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        step_q  <= '0;
                        cnt_q   <= '0;
                        pen_q   <= 1'b0;
                    end
                end
                ST_RUN, ST_REWIND: begin
                    if (state_q == ST_REWIND) cnt_q <= cnt_q + CNT_W'(1);
                    if (mis) begin
                        state_q <= ST_REWIND;
                        step_q  <= row.rewind;
                        end_q   <= step_q;
                        if (span > SP_W'(PENALTY_MAX)) pen_q <= 1'b1;
                    end else if (last_ok) begin
                        state_q <= ST_DONE;
                    end else begin
                        if ((state_q == ST_REWIND) && (step_q == end_q)) state_q <= ST_RUN;
                        step_q <= step_q + STEP_W'(1);
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        done          = (state_q == ST_DONE);
        replay        = (state_q == ST_REWIND);
        replay_cycles = cnt_q;
        penalty_over  = pen_q;
        result        = b_q[0];
    end
endmodule

// File: rtl/dmr_replay_chk.sv
module dmr_replay_chk
    import dmr_sched_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              replay,
    input logic [CNT_W-1:0]  replay_cycles,
    input logic              penalty_over,
    input logic [STEP_W-1:0] step,
    input logic              mis_a,
    input logic              mis_b
);
    a_r4_add_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        mis_a |=> (replay && (step == STEP_W'(A_PRI))));

    a_r5_mul_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        mis_b |=> (replay && (step == STEP_W'(B_PRI))));

    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        replay |=> (replay_cycles == CNT_W'($past(replay_cycles) + CNT_W'(1))));

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_pen_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(penalty_over) |-> $past(mis_a || mis_b));
endmodule

bind dmr_replay_ctrl dmr_replay_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .replay(replay),
    .replay_cycles(replay_cycles), .penalty_over(penalty_over),
    .step(step_q), .mis_a(mis_a), .mis_b(mis_b)
);

// File: tb/dmr_replay_ctrl_tb_top.sv
module dmr_replay_ctrl_tb_top;
    localparam int W     = 16;
    localparam int PW    = 2 * W;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [W-1:0]     opnd_a = '0;
    logic [W-1:0]     opnd_b = '0;
    logic [3:0]       inj_exec = '0;
    logic [3:0]       inj_reg = '0;
    logic [PW-1:0]    result, result_t;
    logic             done, done_t, replay, replay_t, pen, pen_t;
    logic [CNT_W-1:0] rcnt, rcnt_t;

    dmr_replay_ctrl #(.W(W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .inj_exec(inj_exec), .inj_reg(inj_reg), .result(result), .done(done),
        .replay(replay), .replay_cycles(rcnt), .penalty_over(pen));

    dmr_replay_ctrl #(.W(W), .CNT_W(CNT_W), .PENALTY_MAX(3)) dut_tight (
        .clk(clk), .rst_n(rst_n), .start(start), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .inj_exec(inj_exec), .inj_reg(inj_reg), .result(result_t), .done(done_t),
        .replay(replay_t), .replay_cycles(rcnt_t), .penalty_over(pen_t));

    typedef struct {
        logic [PW-1:0] res;
        int            span;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   lat = 0;
    int   rep_seen = 0;
    int   wd = 0;
    bit   tracking = 1'b0;
    bit   rst_checked = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: samples on falling edges, pops expected items on done.
    always @(negedge clk) begin
        exp_t e;
        wd++;
        if (wd > 50000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<50000", wd);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (!rst_n && !rst_checked) begin
            rst_checked = 1'b1;
            check("R1 reset done", 64'(done), 64'd0);
            check("R1 reset replay", 64'(replay), 64'd0);
            check("R1 reset count", 64'(rcnt), 64'd0);
            check("R1 reset result", 64'(result), 64'd0);
            check("R1 reset penalty", 64'(pen), 64'd0);
        end
        if (tracking) begin
            if (replay) rep_seen++;
            if (done) begin
                e = q.pop_front();
                check({e.tag, " R2 result"}, 64'(result), 64'(e.res));
                check({e.tag, " R3 latency"}, 64'(lat), 64'(6 + e.span));
                check({e.tag, " R6 replay count"}, 64'(rcnt), 64'(e.span));
                check({e.tag, " R6 replay flag cycles"}, 64'(rep_seen), 64'(e.span));
                check({e.tag, " R7 penalty default"}, 64'(pen), 64'd0);
                check({e.tag, " R7 penalty tight"}, 64'(pen_t), 64'(e.span > 3));
                check({e.tag, " R2 tight result"}, 64'(result_t), 64'(e.res));
                tracking = 1'b0;
            end else begin
                lat++;
            end
        end else if (start && rst_n) begin
            tracking = 1'b1;
            lat      = 1;
            rep_seen = 0;
        end
    end

    // Driver: kind 0 none, 1 exec fault, 2 register upset; applied in step k on copy idx.
    task automatic run_case(input logic [W-1:0] a, input logic [W-1:0] b, input int kind,
                            input int idx, input int k, input int span, input string tag);
        exp_t e;
        logic [W-1:0] s;
        s     = a + b;
        e.res = PW'(s) * PW'(b);
        e.span = span;
        e.tag  = tag;
        q.push_back(e);
        @(negedge clk); #1;
        opnd_a = a; opnd_b = b; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0; opnd_a = '0; opnd_b = '0;
        if (kind != 0) begin
            repeat (k) @(negedge clk);
            #1;
            if (kind == 1) inj_exec[idx] = 1'b1;
            else           inj_reg[idx]  = 1'b1;
            @(negedge clk); #1;
            inj_exec = '0; inj_reg = '0;
        end
        wait (done);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        run_case(16'd3, 16'd5, 0, 0, 0, 0, "R2 plain");
        run_case(16'hFFFF, 16'd2, 0, 0, 0, 0, "R2 wrap");
        run_case(16'd100, 16'd7, 1, 0, 0, 3, "R4 R8 exec add-pri");
        run_case(16'h1234, 16'h0101, 1, 1, 1, 3, "R4 R8 exec add-sec");
        run_case(16'd9, 16'd11, 2, 0, 1, 3, "R4 R8 upset add-pri");
        run_case(16'h0F0F, 16'h00FF, 1, 2, 3, 4, "R5 R8 exec mul-pri");
        run_case(16'd250, 16'd300, 1, 3, 4, 4, "R5 R8 exec mul-sec");
        run_case(16'hABCD, 16'h0013, 2, 2, 4, 4, "R5 R8 upset mul-pri");
        run_case(16'd77, 16'd44, 2, 3, 5, 0, "R9 late upset mul-sec");
        run_case(16'd21, 16'd2, 2, 0, 3, 0, "R9 late upset add-pri");
        run_case(16'd1, 16'd1, 0, 0, 0, 0, "R1 R6 restart clears");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule